// File: doc/BRIEF.md
# Command Response Status Decoder

This block closes out a memory-card command once the card interface has collected the response. On a one-cycle response-valid strobe it takes the command index, the expected response kind, a busy hint, an initialisation hint, up to sixteen raw response bytes and the number of bytes actually received. In the same decode it checks the length against the kind and screens the card status for error bits. It then produces a status-set vector for the controller's status register, and it may latch the bytes into eight 16-bit response words.

Results appear one clock after the strobe. A single-cycle done pulse comes with them. The status-set vector is meant to be OR-ed into a status register kept elsewhere, so it is zero whenever done is low. The response words hold their value until a later response is accepted for storage.

Top module: `cmd_rsp_decoder`

## Requirements
- R1: `done` is high exactly in the cycle after each cycle with `rsp_valid` high. Whenever `done` is low, `sts_set` is all zeros and `busy_wait` is low.
- R2: With `init_seq` high and `cmd_idx` equal to 0, `sts_set` is 0x0001 whatever the kind or length, and the response words keep their value.
- R3: Kind codes are none=0, normal=1, long=2, operating-condition=3 and address=6. Normal, operating-condition and address responses need `rsp_len` of at least 4, and long needs 16. A shorter response gives `sts_set` bit 7 (timeout) without bit 0, and it leaves the response words unchanged.
- R4: For a normal response, the card word is byte 0 down to byte 3 with byte 0 most significant. If it has any bit set under mask 0xFDF90000, `sts_set` bit 14 (card error) is set.
- R5: For an address response, only the 16-bit value {byte 2, byte 3} is screened, against mask 0xE008. A hit sets `sts_set` bit 14, and bytes 0 and 1 never cause it.
- R6: For an operating-condition response, `sts_set` bit 12 (card still powering up) is set when bit 31 of the card word is clear.
- R7: Every response that does not time out sets `sts_set` bit 0. When `cmd_idx` is 12, bit 2 is set as well.
- R8: A response that passes its length check, of any kind but none, loads response word 7-k with {byte 2k, byte 2k+1}, the even byte in bits 15:8, for k = 0..7. Word r sits in `rsp_word[16r+15:16r]`, and byte k is taken from `rsp_bytes[8k+7:8k]`.
- R9: `busy_wait` is high with `done` exactly when the kind is normal and `busy` was high (the busy variant). For every other kind, `busy` has no effect.
- R10: A kind code outside the five listed is handled as none: no length check, no stored words, and `sts_set` bit 0 (plus bit 2 for command 12).
- R11: An active-low synchronous reset clears `done`, `sts_set`, `busy_wait` and all response words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rsp_valid | input | 1 | One-cycle strobe: response inputs are valid |
| cmd_idx | input | 6 | Index of the command that was issued |
| rsp_kind | input | 3 | Expected response kind code |
| busy | input | 1 | Command signals busy after a normal response |
| init_seq | input | 1 | Command issued as the initialisation sequence |
| rsp_bytes | input | 128 | Raw response bytes, byte k at bits 8k+7:8k |
| rsp_len | input | 5 | Number of valid bytes received (0 to 16) |
| done | output | 1 | One-cycle completion pulse |
| sts_set | output | 16 | Status bits to set, valid with done |
| busy_wait | output | 1 | Completion must wait for card busy release |
| rsp_word | output | 128 | Eight 16-bit response words, word r at bits 16r+15:16r |

## Verification
The decode is driven with each kind at the length boundary: exactly enough bytes and one byte short. This shows that every kind uses its own length and that timeout keeps the stored words. Normal responses carry a masked error bit, an unmasked neighbour (bit 25) and a clean word. Address responses have error bits placed only in bytes 0 and 1, then in bytes 2 and 3, including bit 3. Together these separate the mask contents from the byte selection. Operating-condition words with bit 31 set and clear, command 12 on several kinds, initialisation with index 0 against another index, unlisted kind codes, back-to-back strobes and a reset after stored data cover the remaining orderings.

// File: rtl/cmd_rsp_pkg.sv
// Shared constants and types for the command response decoder.
// Assumes a 16-bit controller status register. Bit positions are fixed by
// the status register that consumes sts_set.
package cmd_rsp_pkg;

    // Response kind codes presented on rsp_kind
    localparam logic [2:0] KIND_NONE   = 3'd0;
    localparam logic [2:0] KIND_NORMAL = 3'd1;
    localparam logic [2:0] KIND_LONG   = 3'd2;
    localparam logic [2:0] KIND_OPCOND = 3'd3;
    localparam logic [2:0] KIND_ADDR   = 3'd6;

    // Status bit positions in sts_set
    localparam int STS_COMPLETE  = 0;
    localparam int STS_STOP      = 2;
    localparam int STS_TIMEOUT   = 7;
    localparam int STS_POWERUP   = 12;
    localparam int STS_CARD_ERR  = 14;

    // Error screens for the card status carried in short responses
    localparam logic [31:0] NORMAL_ERR_MASK = 32'hFDF9_0000;
    localparam logic [15:0] ADDR_ERR_MASK   = 16'hE008;

    // Internal response class after busy promotion
    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_NORMAL,
        CLS_NORMAL_BUSY,
        CLS_LONG,
        CLS_OPCOND,
        CLS_ADDR
    } rsp_class_e;

endpackage

// File: rtl/rsp_kind_decode.sv
// Maps the raw kind code and busy hint onto an internal response class.
// Assumes unlisted codes are treated as "no response". Purely combinational.
module rsp_kind_decode
    import cmd_rsp_pkg::*;
(
    input  logic [2:0]  kind_code,
    input  logic        busy_hint,
    output rsp_class_e  cls
);

    // Decode kind; a normal response with busy is promoted to its busy variant
    always_comb begin
        case (kind_code)
            KIND_NORMAL: cls = busy_hint ? CLS_NORMAL_BUSY : CLS_NORMAL;
            KIND_LONG:   cls = CLS_LONG;
            KIND_OPCOND: cls = CLS_OPCOND;
            KIND_ADDR:   cls = CLS_ADDR;
            default:     cls = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/rsp_status_eval.sv
// Evaluates one response: length check, error screening and the status bits
// to set. Assumes short_word is the card word with byte 0 in bits 31:24.
// Purely combinational; the top registers the results.
module rsp_status_eval
    import cmd_rsp_pkg::*;
#(
    parameter int CMD_W     = 6,
    parameter int LEN_W     = 5,
    parameter int STS_W     = 16,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 16,
    parameter int STOP_CMD  = 12,
    parameter int RESET_CMD = 0
) (
    input  rsp_class_e        cls,
    input  logic [CMD_W-1:0]  cmd_idx,
    input  logic              init_seq,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic [31:0]       short_word,
    output logic [STS_W-1:0]  sts_set,
    output logic              store_en,
    output logic              busy_wait
);

    localparam logic [LEN_W-1:0] SHORT_MIN = LEN_W'(SHORT_LEN);
    localparam logic [LEN_W-1:0] LONG_MIN  = LEN_W'(LONG_LEN);

    logic short_ok;
    logic long_ok;
    logic init_reset;
    logic timed_out;
    logic card_err;

    // Length qualifiers and the initialisation shortcut
    always_comb begin
        short_ok   = (rsp_len >= SHORT_MIN);
        long_ok    = (rsp_len >= LONG_MIN);
        init_reset = init_seq && (cmd_idx == CMD_W'(RESET_CMD));
    end

    // Per-class checks, then the completion / timeout bits
    always_comb begin
        sts_set   = '0;
        store_en  = 1'b0;
        busy_wait = 1'b0;
        timed_out = 1'b0;
        card_err  = 1'b0;
        if (init_reset) begin
            sts_set[STS_COMPLETE] = 1'b1;
        end else begin
            case (cls)
                CLS_NORMAL, CLS_NORMAL_BUSY: begin
                    busy_wait = (cls == CLS_NORMAL_BUSY);
                    if (!short_ok) timed_out = 1'b1;
                    else begin
                        store_en = 1'b1;
                        card_err = |(short_word & NORMAL_ERR_MASK);
                    end
                end
                CLS_LONG: begin
                    if (!long_ok) timed_out = 1'b1;
                    else store_en = 1'b1;
                end
                CLS_OPCOND: begin
                    if (!short_ok) timed_out = 1'b1;
                    else begin
                        store_en = 1'b1;
                        sts_set[STS_POWERUP] = ~short_word[31];
                    end
                end
                CLS_ADDR: begin
                    if (!short_ok) timed_out = 1'b1;
                    else begin
                        store_en = 1'b1;
                        card_err = |(short_word[15:0] & ADDR_ERR_MASK);
                    end
                end
                default: ;
            endcase
            sts_set[STS_CARD_ERR] = card_err;
            if (timed_out) begin
                sts_set[STS_TIMEOUT] = 1'b1;
            end else begin
                sts_set[STS_COMPLETE] = 1'b1;
                sts_set[STS_STOP]     = (cmd_idx == CMD_W'(STOP_CMD));
            end
        end
    end

endmodule

// File: rtl/rsp_word_pack.sv
// Rearranges the response byte array into 16-bit words: byte pair k lands in
// word N_WORDS-1-k, with the even byte in the upper half. Combinational.
module rsp_word_pack #(
    parameter int N_WORDS = 8,
    localparam int N_BYTES = 2 * N_WORDS
) (
    input  logic [8*N_BYTES-1:0]  bytes_in,
    output logic [16*N_WORDS-1:0] words_out
);

    // One lane per byte pair, written in reverse word order
    for (genvar k = 0; k < N_WORDS; k++) begin : g_pair
        localparam int W = N_WORDS - 1 - k;
        assign words_out[16*W +: 16] = {bytes_in[16*k +: 8], bytes_in[16*k+8 +: 8]};
    end

endmodule

// File: rtl/cmd_rsp_decoder.sv
// Top of the command response decoder. Registers the evaluation of a response
// in the cycle after rsp_valid: a done pulse, the status bits to set, the busy
// indication and (on a valid length) the response words.
// Assumes rsp_valid is a single-cycle strobe per response; back-to-back
// strobes are each processed.
module cmd_rsp_decoder
    import cmd_rsp_pkg::*;
#(
    parameter int CMD_W     = 6,
    parameter int STS_W     = 16,
    parameter int N_WORDS   = 8,
    parameter int STOP_CMD  = 12,
    parameter int RESET_CMD = 0,
    localparam int N_BYTES  = 2 * N_WORDS,
    localparam int LEN_W    = $clog2(N_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rsp_valid,
    input  logic [CMD_W-1:0]      cmd_idx,
    input  logic [2:0]            rsp_kind,
    input  logic                  busy,
    input  logic                  init_seq,
    input  logic [8*N_BYTES-1:0]  rsp_bytes,
    input  logic [LEN_W-1:0]      rsp_len,
    output logic                  done,
    output logic [STS_W-1:0]      sts_set,
    output logic                  busy_wait,
    output logic [16*N_WORDS-1:0] rsp_word
);

    rsp_class_e             cls;
    logic [31:0]            short_word;
    logic [STS_W-1:0]       eval_sts;
    logic                   eval_store;
    logic                   eval_busy;
    logic [16*N_WORDS-1:0]  packed_words;

    // Card word from the first four bytes, byte 0 most significant
    always_comb begin
        short_word = {rsp_bytes[7:0], rsp_bytes[15:8], rsp_bytes[23:16], rsp_bytes[31:24]};
    end

    rsp_kind_decode u_kind (
        .kind_code (rsp_kind),
        .busy_hint (busy),
        .cls       (cls)
    );

    rsp_status_eval #(
        .CMD_W     (CMD_W),
        .LEN_W     (LEN_W),
        .STS_W     (STS_W),
        .SHORT_LEN (4),
        .LONG_LEN  (N_BYTES),
        .STOP_CMD  (STOP_CMD),
        .RESET_CMD (RESET_CMD)
    ) u_eval (
        .cls        (cls),
        .cmd_idx    (cmd_idx),
        .init_seq   (init_seq),
        .rsp_len    (rsp_len),
        .short_word (short_word),
        .sts_set    (eval_sts),
        .store_en   (eval_store),
        .busy_wait  (eval_busy)
    );

    rsp_word_pack #(
        .N_WORDS (N_WORDS)
    ) u_pack (
        .bytes_in  (rsp_bytes),
        .words_out (packed_words)
    );

    // Completion pulse and status/busy outputs, zero outside the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            sts_set   <= '0;
            busy_wait <= 1'b0;
        end else begin
            done      <= rsp_valid;
            sts_set   <= rsp_valid ? eval_sts : '0;
            busy_wait <= rsp_valid && eval_busy;
        end
    end

    // Response word storage, loaded only by a response that passed its length check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_word <= '0;
        end else if (rsp_valid && eval_store) begin
            rsp_word <= packed_words;
        end
    end

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> done);                                                    // R1
    AST_QUIET_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (sts_set == '0 && !busy_wait));                               // R1
    AST_TIMEOUT_NO_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_set[STS_TIMEOUT] |-> !sts_set[STS_COMPLETE]);                       // R3
    AST_TIMEOUT_KEEPS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && eval_sts[STS_TIMEOUT]) |=> $stable(rsp_word));            // R3
    AST_ERR_WITH_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_set[STS_CARD_ERR] |-> sts_set[STS_COMPLETE]);                       // R4
    AST_STOP_WITH_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_set[STS_STOP] |-> sts_set[STS_COMPLETE]);                           // R7
    AST_WORDS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> $stable(rsp_word));                                      // R8
    AST_BUSY_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != KIND_NORMAL) |=> !busy_wait);                 // R9

endmodule

// File: tb/cmd_rsp_decoder_test.sv
module cmd_rsp_decoder_test;

    typedef struct packed {
        logic [2:0]   kind;
        logic [5:0]   cmd;
        logic         bsy;
        logic         ini;
        logic [4:0]   len;
        logic [127:0] bytes;
        logic [15:0]  sts;
        logic         bz;
        logic         store;
    } vec_t;

    localparam logic [95:0] UP = 96'hA1A2A3A4_A5A6A7A8_A9AAABAC;
    localparam int NV = 19;

    // kind cmd busy init len bytes exp_sts exp_busy exp_store
    localparam vec_t VECS [NV] = '{
        '{3'd1, 6'd17, 1'b0, 1'b0, 5'd4,  {UP, 32'h00090000}, 16'h0001, 1'b0, 1'b1}, // R4 clean
        '{3'd1, 6'd17, 1'b0, 1'b0, 5'd4,  {UP, 32'h00000080}, 16'h4001, 1'b0, 1'b1}, // R4 bit31
        '{3'd1, 6'd18, 1'b0, 1'b0, 5'd4,  {UP, 32'h00000002}, 16'h0001, 1'b0, 1'b1}, // R4 bit25 unmasked
        '{3'd1, 6'd7,  1'b1, 1'b0, 5'd4,  {UP, 32'h00070000}, 16'h0001, 1'b1, 1'b1}, // R9 busy
        '{3'd1, 6'd12, 1'b1, 1'b0, 5'd4,  {UP, 32'h00090000}, 16'h0005, 1'b1, 1'b1}, // R7 stop
        '{3'd1, 6'd17, 1'b0, 1'b0, 5'd3,  {UP, 32'h11223344}, 16'h0080, 1'b0, 1'b0}, // R3 short
        '{3'd2, 6'd2,  1'b0, 1'b0, 5'd16, 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F, 16'h0001, 1'b0, 1'b1}, // R8 long
        '{3'd2, 6'd9,  1'b0, 1'b0, 5'd15, 128'h55555555555555555555555555555555, 16'h0080, 1'b0, 1'b0}, // R3 long short
        '{3'd3, 6'd41, 1'b1, 1'b0, 5'd4,  {UP, 32'h0080FF00}, 16'h1001, 1'b0, 1'b1}, // R6 powering
        '{3'd3, 6'd41, 1'b0, 1'b0, 5'd4,  {UP, 32'h00FF8080}, 16'h0001, 1'b0, 1'b1}, // R6 ready
        '{3'd6, 6'd3,  1'b0, 1'b0, 5'd4,  {UP, 32'h00051234}, 16'h0001, 1'b0, 1'b1}, // R5 clean
        '{3'd6, 6'd3,  1'b0, 1'b0, 5'd4,  {UP, 32'h00801234}, 16'h4001, 1'b0, 1'b1}, // R5 bit15
        '{3'd6, 6'd3,  1'b0, 1'b0, 5'd4,  {UP, 32'h0000FFFF}, 16'h0001, 1'b0, 1'b1}, // R5 bytes 0,1 ignored
        '{3'd6, 6'd3,  1'b0, 1'b0, 5'd4,  {UP, 32'h08001234}, 16'h4001, 1'b0, 1'b1}, // R5 bit3
        '{3'd0, 6'd0,  1'b0, 1'b0, 5'd0,  128'h77777777777777777777777777777777, 16'h0001, 1'b0, 1'b0}, // R10 none
        '{3'd1, 6'd0,  1'b1, 1'b1, 5'd0,  128'h66666666666666666666666666666666, 16'h0001, 1'b0, 1'b0}, // R2 init
        '{3'd3, 6'd5,  1'b0, 1'b1, 5'd4,  {UP, 32'h00000000}, 16'h1001, 1'b0, 1'b1}, // R2 init other cmd
        '{3'd5, 6'd12, 1'b1, 1'b0, 5'd0,  128'h3C3C3C3C3C3C3C3C3C3C3C3C3C3C3C3C, 16'h0005, 1'b0, 1'b0}, // R10 unlisted
        '{3'd0, 6'd12, 1'b0, 1'b0, 5'd16, 128'h12121212121212121212121212121212, 16'h0005, 1'b0, 1'b0}  // R7 none stop
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rsp_valid = 1'b0;
    logic [5:0]   cmd_idx = '0;
    logic [2:0]   rsp_kind = '0;
    logic         busy = 1'b0;
    logic         init_seq = 1'b0;
    logic [127:0] rsp_bytes = '0;
    logic [4:0]   rsp_len = '0;
    logic         done;
    logic [15:0]  sts_set;
    logic         busy_wait;
    logic [127:0] rsp_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [127:0] exp_words = '0;

    always #2 clk = ~clk;

    cmd_rsp_decoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (rsp_valid),
        .cmd_idx   (cmd_idx),
        .rsp_kind  (rsp_kind),
        .busy      (busy),
        .init_seq  (init_seq),
        .rsp_bytes (rsp_bytes),
        .rsp_len   (rsp_len),
        .done      (done),
        .sts_set   (sts_set),
        .busy_wait (busy_wait),
        .rsp_word  (rsp_word)
    );

    // Expected word layout per R8: word 7-k = {byte 2k, byte 2k+1}
    function automatic logic [127:0] ref_words(input logic [127:0] b);
        logic [127:0] w;
        w = '0;
        for (int k = 0; k < 8; k++)
            w[16*(7-k) +: 16] = {b[16*k +: 8], b[16*k+8 +: 8]};
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        rsp_kind  = v.kind;
        cmd_idx   = v.cmd;
        busy      = v.bsy;
        init_seq  = v.ini;
        rsp_len   = v.len;
        rsp_bytes = v.bytes;
        rsp_valid = 1'b1;
    endtask

    task automatic check_result(input vec_t v, input int idx);
        string tag;
        tag = $sformatf("vec%0d R1/R3-R10", idx);
        if (v.store) exp_words = ref_words(v.bytes);
        chk(done == 1'b1, {tag, " done"}, done, 1);
        chk(sts_set == v.sts, {tag, " sts"}, sts_set, v.sts);
        chk(busy_wait == v.bz, {tag, " busy R9"}, busy_wait, v.bz);
        chk(rsp_word == exp_words, {tag, " words R8"}, rsp_word, exp_words);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(done == 1'b0, "R11 done", done, 0);
        chk(sts_set == '0, "R11 sts", sts_set, 0);
        chk(busy_wait == 1'b0, "R11 busy", busy_wait, 0);
        chk(rsp_word == '0, "R11 words", rsp_word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: one strobe, result, then an idle cycle
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            rsp_valid = 1'b0;
            check_result(VECS[i], i);
            @(negedge clk);
            // R1: pulse is one cycle; outputs quiet, words held
            chk(done == 1'b0, "R1 pulse width", done, 0);
            chk(sts_set == '0, "R1 idle sts", sts_set, 0);
            chk(rsp_word == exp_words, "R8 hold", rsp_word, exp_words);
        end

        // R1: back-to-back strobes are each reported
        drive(VECS[1]);
        @(negedge clk);
        check_result(VECS[1], 101);
        drive(VECS[8]);
        @(negedge clk);
        rsp_valid = 1'b0;
        check_result(VECS[8], 108);
        @(negedge clk);
        chk(done == 1'b0, "R1 after burst", done, 0);

        // R3: busy normal response that times out still flags busy, keeps words
        drive('{3'd1, 6'd13, 1'b1, 1'b0, 5'd2, 128'h9999, 16'h0080, 1'b1, 1'b0});
        @(negedge clk);
        rsp_valid = 1'b0;
        check_result('{3'd1, 6'd13, 1'b1, 1'b0, 5'd2, 128'h9999, 16'h0080, 1'b1, 1'b0}, 200);
        @(negedge clk);

        // R11: reset after stored data clears the words
        rst_n = 1'b0;
        @(negedge clk);
        chk(rsp_word == '0, "R11 words after use", rsp_word, 0);
        chk(done == 1'b0, "R11 done after use", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule